// File: doc/BRIEF.md
# SCSI Bus Phase Control and Mismatch Detector

This block holds the bus-phase control byte of a parallel SCSI controller that can act as either target or initiator. A microcontroller writes and reads the byte through a simple strobe port. In the target role, the byte's REQ and phase bits are driven onto the bus, but only while the target-mode input is 1. In the initiator role with DMA active, the block watches the live REQ line. On each rising edge of REQ it compares the observed MSG, C/D and I/O lines with the programmed phase. If they differ, it raises a sticky phase-mismatch interrupt. An initiator may only move data while the programmed phase equals the observed one, so a mismatch tells firmware to reprogram the byte before moving data.

The block also keeps a last-byte-sent flag. This flag records when the final byte of a DMA transfer has actually gone out on the bus, which is later than the moment that byte leaves the DMA side. Two state machines carry the behaviour.

The mismatch machine has two states:
- MM_IDLE moves to MM_PENDING on a qualified mismatch.
- MM_PENDING returns to MM_IDLE on a clear, unless a new mismatch arrives in the same cycle.

The flag machine has three states:
- LB_ARMED moves to LB_LASTPEND when the final byte is taken from the DMA side.
- LB_LASTPEND moves to LB_SENT when a byte is sent.
- A DMA start returns any state to LB_ARMED.

The bus lines are asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops before use. Arbitration, selection, the DMA engine and the pad drivers lie outside the block.

Top module: `scsi_phase_ctl`

## Requirements
- R1: After reset, `cpu_rdata` is 0, `mismatch_irq` is 0 and all four drive outputs are 0.
- R2: A write (`cpu_wr`=1) stores `cpu_wdata[3:0]` into control bits 3..0, and the stored value reads back on `cpu_rdata[3:0]` from the next cycle. Bit 3 is assert-REQ, bit 2 is MSG, bit 1 is C/D and bit 0 is I/O. `cpu_rdata[6:4]` always reads 0, and `cpu_wdata[6:4]` is ignored.
- R3: While `tgt_mode`=1, `drv_req`, `drv_msg`, `drv_cd` and `drv_io` equal control bits 3, 2, 1 and 0, following `tgt_mode` in the same cycle.
- R4: While `tgt_mode`=0, all four drive outputs are 0, whatever the control bits hold.
- R5: With the default `SYNC_STAGES`=2, a mismatching REQ rise sets `mismatch_irq` at the third rising clock edge after the first edge that samples `bus_req_in` high, and not earlier. The phase lines are sampled through the same synchronizer.
- R6: The comparison is made only when `tgt_mode`=0 and `dma_mode`=1 at the evaluation edge. A mismatch is any difference between bus I/O, C/D, MSG and control bits 0, 1, 2.
- R7: Control bit 3 takes no part in the comparison.
- R8: REQ held high produces exactly one evaluation. A cleared interrupt does not return while REQ stays high.
- R9: `mismatch_irq` stays 1 until an `irq_clr` pulse. A new mismatch evaluated in the same cycle as the clear keeps it at 1.
- R10: The last-byte-sent flag reads on `cpu_rdata[7]`. In the initiator role it becomes 1 on a `byte_sent` pulse in a cycle after the `dma_last_taken` pulse. A `byte_sent` pulse before, or in the same cycle as, `dma_last_taken` leaves it 0.
- R11: `dma_start` in the initiator role clears the flag, takes priority over the other strobes, and re-arms tracking.
- R12: While `tgt_mode`=1, `dma_start`, `dma_last_taken` and `byte_sent` leave the flag unchanged.
- R13: Writing `cpu_wdata[7]` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Microcontroller write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data: flag, zeros, control bits |
| irq_clr | input | 1 | Clear strobe for the mismatch interrupt |
| tgt_mode | input | 1 | 1 = target role with bus drive enabled |
| dma_mode | input | 1 | Initiator DMA active |
| bus_req_in | input | 1 | Live REQ line, active high, asynchronous |
| bus_msg_in | input | 1 | Live MSG line |
| bus_cd_in | input | 1 | Live C/D line |
| bus_io_in | input | 1 | Live I/O line |
| dma_start | input | 1 | A new DMA transfer begins |
| dma_last_taken | input | 1 | Final byte taken from the DMA side |
| byte_sent | input | 1 | A byte has been placed on the bus |
| drv_req | output | 1 | REQ drive request |
| drv_msg | output | 1 | MSG drive request |
| drv_cd | output | 1 | C/D drive request |
| drv_io | output | 1 | I/O drive request |
| mismatch_irq | output | 1 | Sticky phase-mismatch interrupt |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a fresh mismatch evaluation. That evaluation happens two synchronizer stages after the REQ input changes. The stimulus first raises and latches a mismatch and then drops REQ. It raises REQ again with a wrong phase and pulses `irq_clr` exactly in the cycle before the third sampling edge, so the two events coincide. A behavioural model built on a queue of past input samples predicts every output on every cycle, including the single evaluation under a long REQ high.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;

    typedef struct packed {
        logic msg;
        logic cd;
        logic io;
    } phase_bits_t;

    typedef enum logic {
        MM_IDLE,
        MM_PENDING
    } mm_state_t;

    typedef enum logic [1:0] {
        LB_ARMED,
        LB_LASTPEND,
        LB_SENT
    } lb_state_t;

    localparam int CTL_W   = 4;
    localparam int BUS_W   = 4;
    localparam int REQ_BIT = 3;

endpackage

// File: rtl/scsi_phase_sync.sv
module scsi_phase_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic             req_rise
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];
    logic             req_prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= async_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev_q <= 1'b0;
        else        req_prev_q <= stage_q[LAST][WIDTH-1];
    end

    assign sync_out = stage_q[LAST];
    assign req_rise = stage_q[LAST][WIDTH-1] & ~req_prev_q;

endmodule

// File: rtl/scsi_phase_regs.sv
module scsi_phase_regs
    import scsi_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    input  logic             tgt_mode,
    input  logic             lbs_flag,
    output logic [7:0]       cpu_rdata,
    output logic [CTL_W-1:0] ctl_bits,
    output logic [CTL_W-1:0] drive_bits
);
    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (cpu_wr) ctl_q <= cpu_wdata[CTL_W-1:0];
    end

    always_comb begin
        cpu_rdata             = '0;
        cpu_rdata[7]          = lbs_flag;
        cpu_rdata[CTL_W-1:0]  = ctl_q;
        drive_bits            = tgt_mode ? ctl_q : '0;
    end

    assign ctl_bits = ctl_q;

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> cpu_rdata[CTL_W-1:0] == $past(cpu_wdata[CTL_W-1:0]));

endmodule

// File: rtl/scsi_phase_mmfsm.sv
module scsi_phase_mmfsm
    import scsi_phase_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eval_en,
    input  logic        req_rise,
    input  phase_bits_t bus_phase,
    input  phase_bits_t exp_phase,
    input  logic        irq_clr,
    output logic        irq
);
    mm_state_t state_q, state_d;
    logic      mm_event;

    assign mm_event = eval_en & req_rise & (bus_phase != exp_phase);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MM_IDLE:    if (mm_event) state_d = MM_PENDING;
            MM_PENDING: if (!mm_event && irq_clr) state_d = MM_IDLE;
            default:    state_d = MM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == MM_PENDING);
    end

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    // R8
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(req_rise) && $past(eval_en));

endmodule

// File: rtl/scsi_phase_lbs.sv
module scsi_phase_lbs
    import scsi_phase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_mode,
    input  logic dma_start,
    input  logic dma_last_taken,
    input  logic byte_sent,
    output logic lbs_flag
);
    lb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!tgt_mode) begin
            if (dma_start) begin
                state_d = LB_ARMED;
            end else begin
                unique case (state_q)
                    LB_ARMED:    if (dma_last_taken) state_d = LB_LASTPEND;
                    LB_LASTPEND: if (byte_sent)      state_d = LB_SENT;
                    LB_SENT:     state_d = LB_SENT;
                    default:     state_d = LB_ARMED;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LB_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        lbs_flag = (state_q == LB_SENT);
    end

    // R11
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start && !tgt_mode |=> !lbs_flag);

    // R10
    set_on_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lbs_flag) |-> $past(byte_sent) && !$past(tgt_mode));

endmodule

// File: rtl/scsi_phase_ctl.sv
module scsi_phase_ctl
    import scsi_phase_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       irq_clr,
    input  logic       tgt_mode,
    input  logic       dma_mode,
    input  logic       bus_req_in,
    input  logic       bus_msg_in,
    input  logic       bus_cd_in,
    input  logic       bus_io_in,
    input  logic       dma_start,
    input  logic       dma_last_taken,
    input  logic       byte_sent,
    output logic       drv_req,
    output logic       drv_msg,
    output logic       drv_cd,
    output logic       drv_io,
    output logic       mismatch_irq
);
    logic [CTL_W-1:0] ctl_bits;
    logic [CTL_W-1:0] drive_bits;
    logic [BUS_W-1:0] bus_sync;
    logic             req_rise;
    logic             lbs_flag;
    logic             eval_en;
    phase_bits_t      bus_phase;
    phase_bits_t      exp_phase;

    scsi_phase_sync #(.STAGES(SYNC_STAGES), .WIDTH(BUS_W)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_req_in, bus_msg_in, bus_cd_in, bus_io_in}),
        .sync_out (bus_sync),
        .req_rise (req_rise)
    );

    scsi_phase_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .tgt_mode   (tgt_mode),
        .lbs_flag   (lbs_flag),
        .cpu_rdata  (cpu_rdata),
        .ctl_bits   (ctl_bits),
        .drive_bits (drive_bits)
    );

    assign eval_en   = ~tgt_mode & dma_mode;
    assign bus_phase = phase_bits_t'(bus_sync[REQ_BIT-1:0]);
    assign exp_phase = phase_bits_t'(ctl_bits[REQ_BIT-1:0]);

    scsi_phase_mmfsm mm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_en   (eval_en),
        .req_rise  (req_rise),
        .bus_phase (bus_phase),
        .exp_phase (exp_phase),
        .irq_clr   (irq_clr),
        .irq       (mismatch_irq)
    );

    scsi_phase_lbs lbs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tgt_mode       (tgt_mode),
        .dma_start      (dma_start),
        .dma_last_taken (dma_last_taken),
        .byte_sent      (byte_sent),
        .lbs_flag       (lbs_flag)
    );

    assign drv_req = drive_bits[3];
    assign drv_msg = drive_bits[2];
    assign drv_cd  = drive_bits[1];
    assign drv_io  = drive_bits[0];

endmodule

// File: tb/scsi_phase_ctl_tb.sv
module scsi_phase_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq_clr = 1'b0;
    logic       tgt_mode = 1'b0;
    logic       dma_mode = 1'b0;
    logic       bus_req_in = 1'b0, bus_msg_in = 1'b0, bus_cd_in = 1'b0, bus_io_in = 1'b0;
    logic       dma_start = 1'b0, dma_last_taken = 1'b0, byte_sent = 1'b0;
    logic       drv_req, drv_msg, drv_cd, drv_io, mismatch_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    scsi_phase_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_clr(irq_clr), .tgt_mode(tgt_mode),
        .dma_mode(dma_mode), .bus_req_in(bus_req_in), .bus_msg_in(bus_msg_in),
        .bus_cd_in(bus_cd_in), .bus_io_in(bus_io_in), .dma_start(dma_start),
        .dma_last_taken(dma_last_taken), .byte_sent(byte_sent),
        .drv_req(drv_req), .drv_msg(drv_msg), .drv_cd(drv_cd), .drv_io(drv_io),
        .mismatch_irq(mismatch_irq)
    );

    // behavioural reference model
    logic [3:0] hist [$];
    logic [3:0] m_ctl = '0;
    bit         m_irq = 1'b0;
    int         m_lb  = 0;   // 0 armed, 1 waiting for send, 2 sent

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist  = '{4'h0, 4'h0, 4'h0};
            m_ctl = '0;
            m_irq = 1'b0;
            m_lb  = 0;
        end else begin
            bit rise, miss;
            rise = hist[1][3] && !hist[2][3];
            miss = !tgt_mode && dma_mode && rise && (hist[1][2:0] != m_ctl[2:0]);
            if (miss)         m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            if (!tgt_mode) begin
                if (dma_start)                     m_lb = 0;
                else if (m_lb == 0 && dma_last_taken) m_lb = 1;
                else if (m_lb == 1 && byte_sent)   m_lb = 2;
            end
            if (cpu_wr) m_ctl = cpu_wdata[3:0];
            hist.push_front({bus_req_in, bus_msg_in, bus_cd_in, bus_io_in});
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model rdata", cpu_rdata, {(m_lb == 2), 3'b000, m_ctl});
            check("R3/R4 model drive", {4'h0, drv_req, drv_msg, drv_cd, drv_io},
                  {4'h0, tgt_mode ? m_ctl : 4'h0});
            check("R6 model irq", {7'h0, mismatch_irq}, {7'h0, m_irq});
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v; tick(); cpu_wr = 1'b0;
    endtask

    task automatic set_bus(logic r, logic m, logic c, logic i);
        bus_req_in = r; bus_msg_in = m; bus_cd_in = c; bus_io_in = i;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 drive", {4'h0, drv_req, drv_msg, drv_cd, drv_io}, 8'h00);
        check("R1 irq", {7'h0, mismatch_irq}, 8'h00);

        // R2, R13 register write/read
        wr(8'hFF);
        check("R2 reserved read zero", cpu_rdata, 8'h0F);
        check("R13 bit7 write ignored", {7'h0, cpu_rdata[7]}, 8'h00);
        wr(8'h05);
        check("R2 readback", cpu_rdata, 8'h05);

        // R3, R4 target drive
        tgt_mode = 1'b1; #1;
        check("R3 drive 5", {4'h0, drv_req, drv_msg, drv_cd, drv_io}, 8'h05);
        wr(8'h0A);
        check("R3 drive A", {4'h0, drv_req, drv_msg, drv_cd, drv_io}, 8'h0A);
        tgt_mode = 1'b0; #1;
        check("R4 no drive", {4'h0, drv_req, drv_msg, drv_cd, drv_io}, 8'h00);

        // R7 matching phase with REQ bit set: no interrupt
        dma_mode = 1'b1;
        set_bus(1, 0, 1, 0);
        tick(5);
        check("R7 match no irq", {7'h0, mismatch_irq}, 8'h00);
        set_bus(0, 0, 1, 0);
        tick(4);

        // R5, R6 mismatch timing
        set_bus(1, 0, 1, 1);
        tick(2);
        check("R5 not yet", {7'h0, mismatch_irq}, 8'h00);
        tick(1);
        check("R5 irq set", {7'h0, mismatch_irq}, 8'h01);
        // R8 held high, R9 sticky
        tick(6);
        check("R9 sticky", {7'h0, mismatch_irq}, 8'h01);
        pulse_clr();
        tick(6);
        check("R8 single eval", {7'h0, mismatch_irq}, 8'h00);
        set_bus(0, 0, 1, 1);
        tick(4);

        // R6 qualification
        dma_mode = 1'b0;
        set_bus(1, 1, 1, 1);
        tick(5);
        check("R6 dma off", {7'h0, mismatch_irq}, 8'h00);
        set_bus(0, 1, 1, 1); tick(4);
        dma_mode = 1'b1; tgt_mode = 1'b1;
        set_bus(1, 1, 1, 1);
        tick(5);
        check("R6 target role", {7'h0, mismatch_irq}, 8'h00);
        set_bus(0, 1, 1, 1); tick(4);
        tgt_mode = 1'b0;

        // R9 clear coinciding with new mismatch
        set_bus(1, 1, 0, 0); tick(5);
        check("R9 first latch", {7'h0, mismatch_irq}, 8'h01);
        set_bus(0, 1, 0, 0); tick(4);
        set_bus(1, 1, 0, 0);
        tick(2);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        check("R9 event beats clear", {7'h0, mismatch_irq}, 8'h01);
        pulse_clr();
        check("R9 cleared", {7'h0, mismatch_irq}, 8'h00);
        set_bus(0, 0, 0, 0); tick(4);

        // R10 last byte sent
        dma_start = 1'b1; tick(); dma_start = 1'b0;
        byte_sent = 1'b1; tick(); byte_sent = 1'b0;
        check("R10 early send", {7'h0, cpu_rdata[7]}, 8'h00);
        dma_last_taken = 1'b1; byte_sent = 1'b1; tick();
        dma_last_taken = 1'b0; byte_sent = 1'b0;
        check("R10 same cycle", {7'h0, cpu_rdata[7]}, 8'h00);
        tick(2);
        byte_sent = 1'b1; tick(); byte_sent = 1'b0;
        check("R10 set", {7'h0, cpu_rdata[7]}, 8'h01);
        wr(8'h00);
        check("R13 write keeps flag", {7'h0, cpu_rdata[7]}, 8'h01);
        // R12 target role ignores strobes
        tgt_mode = 1'b1;
        dma_start = 1'b1; tick(); dma_start = 1'b0;
        check("R12 start ignored", {7'h0, cpu_rdata[7]}, 8'h01);
        tgt_mode = 1'b0;
        // R11 start clears, priority over send
        dma_start = 1'b1; byte_sent = 1'b1; tick();
        dma_start = 1'b0; byte_sent = 1'b0;
        check("R11 start clears", {7'h0, cpu_rdata[7]}, 8'h00);
        tgt_mode = 1'b1;
        dma_last_taken = 1'b1; tick(); dma_last_taken = 1'b0;
        byte_sent = 1'b1; tick(); byte_sent = 1'b0;
        check("R12 strobes ignored", {7'h0, cpu_rdata[7]}, 8'h00);
        tgt_mode = 1'b0;
        tick(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule